// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds the configuration of a frequency synthesizer core. A host programs it one byte at a time, through an 8-bit parallel bus or through an SPI-style serial port. A static select pin chooses which port is live. Every host write lands in a shadow buffer, and the synthesizer datapath never sees that buffer. The datapath reads an active bank instead. The active bank changes only when a transfer pulse copies the whole shadow buffer into it on one system-clock edge.

Two sources can raise the transfer pulse. In external mode, the rising edge of an update input is synchronized to the system clock, and each rising edge yields one copy. In internal mode, a free-running counter yields one copy every interval-plus-one system clocks. The interval is a 32-bit value held in the buffered set. While internal mode is active, the update pin turns into an output and marks each copy. The mode is taken from bit 0 of the active control word, so a change of mode itself takes effect only through a transfer.

The shadow buffer is clocked by the host strobes: the end of the parallel write strobe, or the serial clock. Host writes and readbacks therefore work while the system clock is stopped. A transfer needs the system clock.

Top module: `cfg_dbuf_regbank`

## Requirements
- R1: With `par_sel` high, the rising edge of `p_wr_n` stores `p_din` into the buffer byte at `p_addr`. While `p_rd_n` is low, `p_doe` is high and `p_dout` shows the buffer byte at `p_addr`.
- R2: With `par_sel` low and `s_cs_n` low, bits on `s_di` are taken on rising `s_clk`, MSB first. The first byte is an instruction: bit 7 = 1 for read, 0 for write; bit 6 is ignored; bits 5:0 give the start address. Each following data byte is written to the current address, and the address then steps up by one.
- R3: In a serial read, `s_do` presents each data bit, MSB first, before the rising `s_clk` edge that consumes it. Data comes from consecutive buffer bytes starting at the instruction address.
- R4: Addresses 0x28 to 0x3F are unmapped. Writes to them change nothing, and reads of them return 0 on both ports.
- R5: Host writes change no field output, `upd_oe` or `int_upd_active` until a transfer occurs.
- R6: A transfer copies every buffered byte into the active bank on one system-clock edge. All field outputs change together at that edge.
- R7: The byte map is big-endian, with the most significant byte at the lowest address. Each field takes the low bits of its bytes. The map is: control 0x00–0x03 (bit 0 = internal update enable); interval 0x04–0x07; tuning word A 0x08–0x0D; tuning word B 0x0E–0x13; phase A 0x14–0x15 (14 bits); phase B 0x16–0x17 (14 bits); frequency step 0x18–0x1D; ramp count 0x1E–0x20 (20 bits); I amplitude 0x21–0x22; Q amplitude 0x23–0x24; output ramp rate 0x25; auxiliary DAC 0x26–0x27 (12 bits).
- R8: In external mode, a rising edge on `upd_in` causes exactly one transfer, on the third rising `clk` edge after the input rises. Holding `upd_in` high causes no further transfer.
- R9: When the active control bit 0 is 1, a transfer occurs every interval+1 clocks and `upd_in` is ignored. `int_upd_active` equals the active control bit 0.
- R10: `upd_oe` equals `int_upd_active`. `upd_out` is high for exactly the cycle that follows each internal-mode transfer edge, and is otherwise low.
- R11: Buffer writes and readbacks through the host port work while `clk` is stopped. The written data reaches the fields at the next transfer once `clk` runs.
- R12: After reset, the buffer and all field outputs are zero, the block is in external mode, and `upd_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_sel | input | 1 | Static port select: 1 parallel, 0 serial |
| p_addr | input | 6 | Parallel byte address |
| p_din | input | 8 | Parallel write data |
| p_wr_n | input | 1 | Parallel write strobe, active low, data taken on rising edge |
| p_rd_n | input | 1 | Parallel read strobe, active low |
| p_dout | output | 8 | Parallel read data |
| p_doe | output | 1 | Parallel data output enable |
| s_clk | input | 1 | Serial clock |
| s_cs_n | input | 1 | Serial chip select, active low |
| s_di | input | 1 | Serial data in |
| s_do | output | 1 | Serial data out |
| upd_in | input | 1 | External update request |
| upd_out | output | 1 | Update pin drive value in internal mode |
| upd_oe | output | 1 | Update pin output enable |
| int_upd_active | output | 1 | Internal update mode active |
| ctrl_word | output | 32 | Active control word |
| ftw_a | output | 48 | Active tuning word A |
| ftw_b | output | 48 | Active tuning word B |
| phase_a | output | 14 | Active phase offset A |
| phase_b | output | 14 | Active phase offset B |
| freq_step | output | 48 | Active frequency step |
| ramp_cnt | output | 20 | Active ramp-rate count |
| amp_i | output | 16 | Active I amplitude multiplier |
| amp_q | output | 16 | Active Q amplitude multiplier |
| out_ramp | output | 8 | Active output ramp rate |
| aux_dac | output | 12 | Active auxiliary DAC value |

## Verification
A corrupt shadow byte stays hidden until a host readback or the next transfer. A readback exposes it within one strobe. A transfer puts it on a field output at that same clock edge. A wrong counter or synchronizer state appears on the field outputs and on `upd_out` in the first cycle the transfer is early, late, doubled or missing. The reference model compares every field and pin on every clock, so such a slip is reported in the cycle it happens.

// File: rtl/cfg_regmap_pkg.sv
package cfg_regmap_pkg;
  localparam int AW     = 6;
  localparam int NBYTES = 40;

  // byte offsets (big-endian: MSB at lowest address)
  localparam int OFF_CTRL  = 0;   localparam int LEN_CTRL  = 4;  localparam int W_CTRL  = 32;
  localparam int OFF_IVL   = 4;   localparam int LEN_IVL   = 4;  localparam int W_IVL   = 32;
  localparam int OFF_FTWA  = 8;   localparam int LEN_FTW   = 6;  localparam int W_FTW   = 48;
  localparam int OFF_FTWB  = 14;
  localparam int OFF_PHA   = 20;  localparam int LEN_PH    = 2;  localparam int W_PH    = 14;
  localparam int OFF_PHB   = 22;
  localparam int OFF_STEP  = 24;  localparam int LEN_STEP  = 6;  localparam int W_STEP  = 48;
  localparam int OFF_RCNT  = 30;  localparam int LEN_RCNT  = 3;  localparam int W_RCNT  = 20;
  localparam int OFF_AMPI  = 33;  localparam int LEN_AMP   = 2;  localparam int W_AMP   = 16;
  localparam int OFF_AMPQ  = 35;
  localparam int OFF_ORMP  = 37;  localparam int LEN_ORMP  = 1;  localparam int W_ORMP  = 8;
  localparam int OFF_AUX   = 38;  localparam int LEN_AUX   = 2;  localparam int W_AUX   = 12;

  localparam int INT_EN_BIT = 0;

  // LSB position of a field inside the flattened bank (byte 0 at the top)
  function automatic int fld_lsb(input int off, input int len);
    return (NBYTES - off - len) * 8;
  endfunction
endpackage

// File: rtl/cfg_host_port.sv
module cfg_host_port
  import cfg_regmap_pkg::*;
(
  input  logic                rst_n,
  input  logic                par_sel,
  input  logic [AW-1:0]       p_addr,
  input  logic [7:0]          p_din,
  input  logic                p_wr_n,
  input  logic                p_rd_n,
  output logic [7:0]          p_dout,
  output logic                p_doe,
  input  logic                s_clk,
  input  logic                s_cs_n,
  input  logic                s_di,
  output logic                s_do,
  output logic [NBYTES*8-1:0] buf_flat
);
  localparam logic [AW-1:0] LAST = AW'(NBYTES - 1);

  logic [7:0] mem [NBYTES];

  // serial engine state, cleared whenever chip select is high
  logic          ser_rst_n;
  logic [2:0]    bit_cnt;
  logic [6:0]    sh;
  logic          in_data;
  logic          is_rd;
  logic [AW-1:0] saddr;
  logic          byte_end;

  assign ser_rst_n = rst_n & ~s_cs_n;
  assign byte_end  = (bit_cnt == 3'd7);

  always_ff @(posedge s_clk or negedge ser_rst_n) begin
    if (!ser_rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
      in_data <= 1'b0;
      is_rd   <= 1'b0;
      saddr   <= '0;
    end else begin
      sh      <= {sh[5:0], s_di};
      bit_cnt <= bit_cnt + 3'd1;
      if (byte_end) begin
        if (!in_data) begin
          in_data <= 1'b1;
          is_rd   <= sh[6];
          saddr   <= {sh[4:0], s_di};
        end else begin
          saddr   <= saddr + AW'(1);
        end
      end
    end
  end

  // shadow buffer: clocked by whichever host strobe is live
  logic hck;
  assign hck = par_sel ? p_wr_n : s_clk;

  always_ff @(posedge hck or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NBYTES; k++) mem[k] <= '0;
    end else if (par_sel) begin
      if (p_addr <= LAST) mem[p_addr] <= p_din;
    end else if (!s_cs_n && in_data && !is_rd && byte_end && (saddr <= LAST)) begin
      mem[saddr] <= {sh, s_di};
    end
  end

  // readback paths
  logic [7:0] ser_byte;
  assign p_doe    = par_sel & ~p_rd_n;
  assign p_dout   = (p_doe && (p_addr <= LAST)) ? mem[p_addr] : 8'h00;
  assign ser_byte = (saddr <= LAST) ? mem[saddr] : 8'h00;
  assign s_do     = (!par_sel && !s_cs_n && in_data && is_rd) ? ser_byte[~bit_cnt] : 1'b0;

  for (genvar k = 0; k < NBYTES; k++) begin : g_flat
    assign buf_flat[(NBYTES-1-k)*8 +: 8] = mem[k];
  end
endmodule

// File: rtl/cfg_update_ctl.sv
module cfg_update_ctl #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_mode,
  input  logic [CNT_W-1:0] interval,
  input  logic             upd_in,
  output logic             xfer,
  output logic             upd_out
);
  logic             sy0, sy1, sy1_d;
  logic [CNT_W-1:0] cnt;
  logic             ext_rise, int_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy0   <= 1'b0;
      sy1   <= 1'b0;
      sy1_d <= 1'b0;
    end else begin
      sy0   <= upd_in;
      sy1   <= sy0;
      sy1_d <= sy1;
    end
  end

  assign ext_rise = sy1 & ~sy1_d;
  assign int_hit  = (cnt == interval);
  assign xfer     = int_mode ? int_hit : ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      upd_out <= 1'b0;
    end else begin
      upd_out <= int_mode & int_hit;
      if (!int_mode || int_hit) cnt <= '0;
      else                      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_EXT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_mode && xfer) |=> !(!int_mode && xfer)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int_mode |-> (cnt <= interval)); // R9
  AST_PIN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    upd_out |-> $past(int_mode)); // R10
endmodule

// File: rtl/cfg_active_bank.sv
module cfg_active_bank #(
  parameter int BITS = 320
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer,
  input  logic [BITS-1:0] buf_flat,
  output logic [BITS-1:0] act_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_flat <= '0;
    else if (xfer) act_flat <= buf_flat;
  end

  AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (act_flat == $past(buf_flat))); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(act_flat)); // R5
endmodule

// File: rtl/cfg_dbuf_regbank.sv
module cfg_dbuf_regbank
  import cfg_regmap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          par_sel,
  input  logic [AW-1:0] p_addr,
  input  logic [7:0]    p_din,
  input  logic          p_wr_n,
  input  logic          p_rd_n,
  output logic [7:0]    p_dout,
  output logic          p_doe,
  input  logic          s_clk,
  input  logic          s_cs_n,
  input  logic          s_di,
  output logic          s_do,
  input  logic          upd_in,
  output logic          upd_out,
  output logic          upd_oe,
  output logic          int_upd_active,
  output logic [W_CTRL-1:0] ctrl_word,
  output logic [W_FTW-1:0]  ftw_a,
  output logic [W_FTW-1:0]  ftw_b,
  output logic [W_PH-1:0]   phase_a,
  output logic [W_PH-1:0]   phase_b,
  output logic [W_STEP-1:0] freq_step,
  output logic [W_RCNT-1:0] ramp_cnt,
  output logic [W_AMP-1:0]  amp_i,
  output logic [W_AMP-1:0]  amp_q,
  output logic [W_ORMP-1:0] out_ramp,
  output logic [W_AUX-1:0]  aux_dac
);
  localparam int BITS   = NBYTES * 8;
  localparam int L_CTRL = fld_lsb(OFF_CTRL, LEN_CTRL);
  localparam int L_IVL  = fld_lsb(OFF_IVL,  LEN_IVL);
  localparam int L_FTWA = fld_lsb(OFF_FTWA, LEN_FTW);
  localparam int L_FTWB = fld_lsb(OFF_FTWB, LEN_FTW);
  localparam int L_PHA  = fld_lsb(OFF_PHA,  LEN_PH);
  localparam int L_PHB  = fld_lsb(OFF_PHB,  LEN_PH);
  localparam int L_STEP = fld_lsb(OFF_STEP, LEN_STEP);
  localparam int L_RCNT = fld_lsb(OFF_RCNT, LEN_RCNT);
  localparam int L_AMPI = fld_lsb(OFF_AMPI, LEN_AMP);
  localparam int L_AMPQ = fld_lsb(OFF_AMPQ, LEN_AMP);
  localparam int L_ORMP = fld_lsb(OFF_ORMP, LEN_ORMP);
  localparam int L_AUX  = fld_lsb(OFF_AUX,  LEN_AUX);
  localparam int PH_PAD = LEN_PH * 8 - W_PH;
  localparam int RC_PAD = LEN_RCNT * 8 - W_RCNT;
  localparam int AX_PAD = LEN_AUX * 8 - W_AUX;

  logic [BITS-1:0]  buf_flat, act_flat;
  logic             xfer;
  logic [W_IVL-1:0] interval;

  cfg_host_port u_host (
    .rst_n   (rst_n),
    .par_sel (par_sel),
    .p_addr  (p_addr),
    .p_din   (p_din),
    .p_wr_n  (p_wr_n),
    .p_rd_n  (p_rd_n),
    .p_dout  (p_dout),
    .p_doe   (p_doe),
    .s_clk   (s_clk),
    .s_cs_n  (s_cs_n),
    .s_di    (s_di),
    .s_do    (s_do),
    .buf_flat(buf_flat)
  );

  cfg_update_ctl #(.CNT_W(W_IVL)) u_upd (
    .clk     (clk),
    .rst_n   (rst_n),
    .int_mode(int_upd_active),
    .interval(interval),
    .upd_in  (upd_in),
    .xfer    (xfer),
    .upd_out (upd_out)
  );

  cfg_active_bank #(.BITS(BITS)) u_act (
    .clk     (clk),
    .rst_n   (rst_n),
    .xfer    (xfer),
    .buf_flat(buf_flat),
    .act_flat(act_flat)
  );

  assign ctrl_word      = act_flat[L_CTRL +: W_CTRL];
  assign interval       = act_flat[L_IVL  +: W_IVL];
  assign ftw_a          = act_flat[L_FTWA +: W_FTW];
  assign ftw_b          = act_flat[L_FTWB +: W_FTW];
  assign phase_a        = act_flat[L_PHA  +: W_PH];
  assign phase_b        = act_flat[L_PHB  +: W_PH];
  assign freq_step      = act_flat[L_STEP +: W_STEP];
  assign ramp_cnt       = act_flat[L_RCNT +: W_RCNT];
  assign amp_i          = act_flat[L_AMPI +: W_AMP];
  assign amp_q          = act_flat[L_AMPQ +: W_AMP];
  assign out_ramp       = act_flat[L_ORMP +: W_ORMP];
  assign aux_dac        = act_flat[L_AUX  +: W_AUX];
  assign int_upd_active = ctrl_word[INT_EN_BIT];
  assign upd_oe         = int_upd_active;

  // pad bits above narrow fields are stored for readback but drive nothing
  logic unused_pad_bits;
  assign unused_pad_bits = ^{act_flat[L_PHA + W_PH +: PH_PAD], act_flat[L_PHB + W_PH +: PH_PAD],
                             act_flat[L_RCNT + W_RCNT +: RC_PAD], act_flat[L_AUX + W_AUX +: AX_PAD]};
endmodule

// File: tb/sim_cfg_dbuf_regbank.sv
module sim_cfg_dbuf_regbank;
  import cfg_regmap_pkg::*;

  logic clk = 1'b0, clk_run = 1'b1;
  always #2 if (clk_run || clk) clk = ~clk;   // 250 MHz

  logic rst_n = 1'b0, par_sel = 1'b1;
  logic [5:0] p_addr = '0;
  logic [7:0] p_din = '0;
  logic p_wr_n = 1'b1, p_rd_n = 1'b1;
  logic s_clk = 1'b0, s_cs_n = 1'b1, s_di = 1'b0, upd_in = 1'b0;
  logic [7:0] p_dout;
  logic p_doe, s_do, upd_out, upd_oe, int_upd_active;
  logic [31:0] ctrl_word;
  logic [47:0] ftw_a, ftw_b, freq_step;
  logic [13:0] phase_a, phase_b;
  logic [19:0] ramp_cnt;
  logic [15:0] amp_i, amp_q;
  logic [7:0]  out_ramp;
  logic [11:0] aux_dac;

  cfg_dbuf_regbank u0 (.*);

  int vectors = 0, fails = 0;
  logic [7:0] mbuf [NBYTES];
  logic [7:0] mact [NBYTES];
  logic [31:0] mcnt;
  logic h0, h1, h2, exp_uo, m_tick, m_im;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] getf(input int off, input int len, input int w);
    logic [63:0] v = '0;
    for (int i = 0; i < len; i++) v = (v << 8) | 64'(mact[off+i]);
    return v & ((64'd1 << w) - 64'd1);
  endfunction

  // behavioural reference: transfer timing and active copy
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mact[i] = '0;
      mcnt = 0; h0 = 0; h1 = 0; h2 = 0; exp_uo = 0;
    end else begin
      m_im = mact[3][0];
      if (m_im) begin
        m_tick = (mcnt == {mact[4], mact[5], mact[6], mact[7]});
        mcnt = m_tick ? 32'd0 : mcnt + 32'd1;
      end else begin
        m_tick = h1 && !h2;
        mcnt = 0;
      end
      exp_uo = m_im && m_tick;
      h2 = h1; h1 = h0; h0 = upd_in;
      if (m_tick) for (int i = 0; i < NBYTES; i++) mact[i] = mbuf[i];
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R6 ctrl",   64'(ctrl_word), getf(0, 4, 32));
    chk("R6 ftw_a",  64'(ftw_a),     getf(8, 6, 48));
    chk("R6 ftw_b",  64'(ftw_b),     getf(14, 6, 48));
    chk("R7 ph_a",   64'(phase_a),   getf(20, 2, 14));
    chk("R7 ph_b",   64'(phase_b),   getf(22, 2, 14));
    chk("R6 step",   64'(freq_step), getf(24, 6, 48));
    chk("R7 rcnt",   64'(ramp_cnt),  getf(30, 3, 20));
    chk("R6 amp_i",  64'(amp_i),     getf(33, 2, 16));
    chk("R6 amp_q",  64'(amp_q),     getf(35, 2, 16));
    chk("R6 oramp",  64'(out_ramp),  getf(37, 1, 8));
    chk("R7 aux",    64'(aux_dac),   getf(38, 2, 12));
    chk("R10 upd_out", 64'(upd_out), 64'(exp_uo));
    chk("R10 upd_oe",  64'(upd_oe),  64'(mact[3][0]));
    chk("R9 int_act",  64'(int_upd_active), 64'(mact[3][0]));
  end

  // host tasks: all edges land on clk falling-edge times
  task automatic pwr(input logic [5:0] a, input logic [7:0] d);
    p_addr = a; p_din = d;
    #4 p_wr_n = 1'b0;
    #4 p_wr_n = 1'b1;
    if (a < NBYTES) mbuf[a] = d;
    #4;
  endtask

  task automatic pwr_n(input logic [5:0] a, input logic [47:0] v, input int n);
    for (int i = 0; i < n; i++) pwr(a + 6'(i), v[(n-1-i)*8 +: 8]);
  endtask

  task automatic prd(input logic [5:0] a, input logic [7:0] exp, input string tag);
    p_addr = a; p_rd_n = 1'b0;
    #4 chk(tag, 64'(p_dout), 64'(exp));
    chk(tag, 64'(p_doe), 64'd1);
    p_rd_n = 1'b1;
    #4;
  endtask

  task automatic sbyte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      s_di = b[i];
      #4 s_clk = 1'b1;
      #4 s_clk = 1'b0;
    end
  endtask

  task automatic swr(input logic [5:0] a, input logic [47:0] v, input int n);
    s_cs_n = 1'b0; #4;
    sbyte_out({2'b00, a});
    for (int i = 0; i < n; i++) begin
      sbyte_out(v[(n-1-i)*8 +: 8]);
      if (a + i < NBYTES) mbuf[a+i] = v[(n-1-i)*8 +: 8];
    end
    s_cs_n = 1'b1; #4;
  endtask

  task automatic srd(input logic [5:0] a, input int n, output logic [47:0] v);
    v = '0;
    s_cs_n = 1'b0; #4;
    sbyte_out({2'b10, a});
    for (int i = 0; i < n * 8; i++) begin
      v = {v[46:0], s_do};
      #4 s_clk = 1'b1;
      #4 s_clk = 1'b0;
    end
    s_cs_n = 1'b1; #4;
  endtask

  task automatic ext_pulse();
    @(negedge clk) upd_in = 1'b1;
    repeat (4) @(negedge clk);
    upd_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk) rst_n = 1'b0;
    par_sel = mode;
    for (int i = 0; i < NBYTES; i++) mbuf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [47:0] rv;
    int n;
    do_reset(1'b1);
    chk("R12 ftw_a", 64'(ftw_a), 64'd0);
    chk("R12 upd_oe", 64'(upd_oe), 64'd0);
    chk("R12 upd_out", 64'(upd_out), 64'd0);

    // parallel writes (R1, R7), isolation (R5)
    @(negedge clk);
    pwr_n(6'd8,  48'h1234_5678_9ABC, 6);
    pwr_n(6'd20, 48'hEABC, 2);
    pwr_n(6'd30, 48'hFF1234, 3);
    pwr_n(6'd33, 48'hBEEF, 2);
    pwr(6'd37, 8'h5A);
    pwr_n(6'd38, 48'hFFED, 2);
    prd(6'd8, 8'h12, "R7");
    prd(6'd9, 8'h34, "R1");
    prd(6'd37, 8'h5A, "R1");
    prd(6'd20, 8'hEA, "R1");
    pwr(6'h30, 8'hFF);
    prd(6'h30, 8'h00, "R4");
    prd(6'h3F, 8'h00, "R4");
    chk("R5 ftw_a held", 64'(ftw_a), 64'd0);
    ext_pulse();
    chk("R6 ftw_a", 64'(ftw_a), 64'h1234_5678_9ABC);
    chk("R7 phase_a", 64'(phase_a), 64'h2ABC);

    // external latency and single copy (R8)
    @(negedge clk);
    pwr_n(6'd14, 48'hA5A5_0F0F_3C3C, 6);
    @(negedge clk) upd_in = 1'b1;
    @(negedge clk) chk("R8 edge1", 64'(ftw_b), 64'd0);
    @(negedge clk) chk("R8 edge2", 64'(ftw_b), 64'd0);
    @(negedge clk) chk("R8 edge3", 64'(ftw_b), 64'hA5A5_0F0F_3C3C);
    pwr(6'd19, 8'h11);
    repeat (6) @(negedge clk);
    chk("R8 held high", 64'(ftw_b), 64'hA5A5_0F0F_3C3C);
    upd_in = 1'b0;
    repeat (4) @(negedge clk);

    // internal mode (R9, R10)
    pwr_n(6'd4, 48'd9, 4);
    pwr_n(6'd0, 48'd1, 4);
    ext_pulse();
    chk("R9 int on", 64'(int_upd_active), 64'd1);
    n = 0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (upd_out) n++;
      if (c % 3 == 0) upd_in = ~upd_in;
    end
    upd_in = 1'b0;
    chk("R9 pulses in 50", 64'(n), 64'd5);
    chk("R10 oe", 64'(upd_oe), 64'd1);
    pwr_n(6'd24, 48'h0102_0304_0506, 6);
    pwr_n(6'd0, 48'd0, 4);
    repeat (24) @(negedge clk);
    chk("R9 int off", 64'(int_upd_active), 64'd0);
    chk("R6 step", 64'(freq_step), 64'h0102_0304_0506);

    // serial port (R2, R3, R4, R11, R12)
    do_reset(1'b0);
    chk("R12 serial ftw_a", 64'(ftw_a), 64'd0);
    @(negedge clk);
    swr(6'd14, 48'hCAFE_F00D_1234, 6);
    srd(6'd14, 6, rv);
    chk("R3 read ftw_b", 64'(rv), 64'hCAFE_F00D_1234);
    srd(6'h3E, 1, rv);
    chk("R4 serial unmapped", 64'(rv), 64'd0);
    swr(6'd37, 48'h77, 1);
    chk("R5 oramp held", 64'(out_ramp), 64'd0);
    @(negedge clk) clk_run = 1'b0;
    #8;
    swr(6'd20, 48'h1357, 2);
    srd(6'd20, 2, rv);
    chk("R11 read no clk", 64'(rv), 64'h1357);
    clk_run = 1'b1;
    ext_pulse();
    chk("R11 phase_a", 64'(phase_a), 64'h1357);
    chk("R2 ftw_b", 64'(ftw_b), 64'hCAFE_F00D_1234);
    chk("R2 oramp", 64'(out_ramp), 64'h77);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule